// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block runs one atomic read-modify-write access on behalf of a processor that has a write-back cache and a posted write buffer. When a locked request is accepted, the block first waits until the write buffer has emptied. It then looks the target address up in the cache. If the cache holds the line, the cached copy is pushed out of the way before anything reaches the bus: a dirty line is copied back and then invalidated, and a clean line is invalidated. The block then issues an external read and an external write to the same address, and drives a lock output for as long as those two bus commands last.

The cached copy of the data is never used. Every locked access appears on the external bus, whether the cache hit or missed. A bus hold request is granted only while the block is idle or draining the write buffer. A back-off request or an address-hold request pauses the locked bus command without ending the lock. The interrupted command is issued again, with the same operation and address, once the pause is over. Until the block signals completion, it accepts no further request.

Top module: `locked_rmw_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `lock_out`, `resp_valid`, `lkup_req`, `cache_cmd_valid` and `bus_cmd_valid` are all 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the `resp_valid` pulse. A `req_valid` raised while `req_ready` is low has no effect: it produces no cache command and no bus command.
- R3: No cache lookup (`lkup_req` high) happens while `wbuf_empty` is low. `wbuf_flush` is high while the block waits for the buffer to drain.
- R4: On a lookup miss, the only commands are a bus read (`bus_cmd_write`=0) followed by a bus write (`bus_cmd_write`=1), both to the request address. No cache command is issued.
- R5: On a clean hit (`lkup_hit`=1, `lkup_dirty`=0), the block issues an invalidate (`cache_cmd_copyback`=0), then the bus read, then the bus write.
- R6: On a dirty hit (`lkup_hit`=1, `lkup_dirty`=1), the block issues a copy-back (`cache_cmd_copyback`=1), then an invalidate, then the bus read, then the bus write. No cache command is ever issued while `lock_out` is high.
- R7: `lock_out` is high from the first cycle of the locked read through the cycle in which the locked write completes. It is low in every other cycle. The first command issued under lock is always a read.
- R8: `hold_ack` follows `hold_req` only while the block is idle or draining. While the block is draining, it does not move on to the lookup as long as `hold_req` is high. `hold_ack` is never high together with `lock_out`.
- R9: While `boff` or `ahold` is high, `bus_cmd_valid` is low and `lock_out` stays high. A command cut short by either input is issued again afterwards, with the same operation and address, and it completes only once.
- R10: A bus command completes in a cycle where `bus_cmd_valid` and `bus_done` are both high. The locked write carries the request's `req_wdata` on `bus_wdata`. One cycle after the write completes, `resp_valid` pulses for one cycle with the data returned by the locked read on `resp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Locked request strobe |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Data for the locked write |
| req_ready | output | 1 | High only while idle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DW | Data from the locked read |
| wbuf_empty | input | 1 | Posted write buffer is empty |
| wbuf_flush | output | 1 | Waiting for write buffer to drain |
| lkup_req | output | 1 | Cache lookup strobe |
| lkup_addr | output | AW | Lookup address |
| lkup_hit | input | 1 | Lookup hit, valid while lkup_req is high |
| lkup_dirty | input | 1 | Hit line is modified |
| cache_cmd_valid | output | 1 | Cache maintenance command pending |
| cache_cmd_copyback | output | 1 | 1 = copy back, 0 = invalidate |
| cache_cmd_addr | output | AW | Maintenance address |
| cache_done | input | 1 | Maintenance command finished |
| bus_cmd_valid | output | 1 | Locked bus command pending |
| bus_cmd_write | output | 1 | 1 = write, 0 = read |
| bus_cmd_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with bus_done |
| bus_done | input | 1 | Bus command finished |
| lock_out | output | 1 | Bus lock indicator |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Bus hold grant |
| boff | input | 1 | Back-off request |
| ahold | input | 1 | Address hold request |

## Verification
Two pairs of events can land in the same cycle. In the first, a hold request is still pending in the cycle the write buffer reports empty. The bench provokes this by raising `hold_req` during the drain and only then setting `wbuf_empty`. It passes only if the grant stays up and neither a lookup nor any command appears until the hold is dropped. In the second, a back-off or address-hold request arrives while a locked read or write is pending but not yet done. The bench raises `boff` on the read and `ahold` on the write one cycle after each command appears. It passes only if the bus command goes quiet while `lock_out` stays high, and the scoreboard then sees exactly one completion of each command, in the expected order.

// File: rtl/locked_rmw_seq.sv
module locked_rmw_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          wbuf_empty,
  output logic          wbuf_flush,
  output logic          lkup_req,
  output logic [AW-1:0] lkup_addr,
  input  logic          lkup_hit,
  input  logic          lkup_dirty,
  output logic          cache_cmd_valid,
  output logic          cache_cmd_copyback,
  output logic [AW-1:0] cache_cmd_addr,
  input  logic          cache_done,
  output logic          bus_cmd_valid,
  output logic          bus_cmd_write,
  output logic [AW-1:0] bus_cmd_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  output logic          lock_out,
  input  logic          hold_req,
  output logic          hold_ack,
  input  logic          boff,
  input  logic          ahold
);

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_LOOKUP, S_COPYBACK, S_INVAL, S_LRD, S_LWR, S_REL
  } st_t;

  st_t st, st_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  wire locked  = (st == S_LRD) || (st == S_LWR);
  wire bus_go  = locked && !boff && !ahold;
  wire bus_fin = bus_go && bus_done;

  assign req_ready          = (st == S_IDLE);
  assign resp_valid         = (st == S_REL);
  assign resp_rdata         = rdata_q;
  assign wbuf_flush         = (st == S_DRAIN);
  assign lkup_req           = (st == S_LOOKUP);
  assign lkup_addr          = addr_q;
  assign cache_cmd_valid    = (st == S_COPYBACK) || (st == S_INVAL);
  assign cache_cmd_copyback = (st == S_COPYBACK);
  assign cache_cmd_addr     = addr_q;
  assign bus_cmd_valid      = bus_go;
  assign bus_cmd_write      = (st == S_LWR);
  assign bus_cmd_addr       = addr_q;
  assign bus_wdata          = wdata_q;
  assign lock_out           = locked;
  assign hold_ack           = hold_req && ((st == S_IDLE) || (st == S_DRAIN));

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:     if (req_valid) st_n = S_DRAIN;
      S_DRAIN:    if (wbuf_empty && !hold_req) st_n = S_LOOKUP;
      S_LOOKUP:   st_n = !lkup_hit ? S_LRD : (lkup_dirty ? S_COPYBACK : S_INVAL);
      S_COPYBACK: if (cache_done) st_n = S_INVAL;
      S_INVAL:    if (cache_done) st_n = S_LRD;
      S_LRD:      if (bus_fin) st_n = S_LWR;
      S_LWR:      if (bus_fin) st_n = S_REL;
      default:    st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st <= st_n;
      if (st == S_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (st == S_LRD && bus_fin) rdata_q <= bus_rdata;
    end
  end

  a_r8_no_grant_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> !hold_ack);
  a_r9_quiet_on_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    (boff || ahold) |-> !bus_cmd_valid);
  a_r7_lock_opens_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_out) |-> !bus_cmd_write);
  a_r6_no_cache_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cache_cmd_valid |-> !lock_out);
  a_r10_resp_follows_lock: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(lock_out) && !lock_out);
  a_r3_lookup_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lkup_req) |-> $past(wbuf_empty) && !$past(hold_req));
  a_r2_ready_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lock_out && !cache_cmd_valid);

endmodule

// File: tb/locked_rmw_seq_bench.sv
module locked_rmw_seq_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 0, wbuf_empty = 1, lkup_hit = 0, lkup_dirty = 0;
  logic cache_done = 0, bus_done = 0, hold_req = 0, boff = 0, ahold = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic req_ready, resp_valid, wbuf_flush, lkup_req, cache_cmd_valid, cache_cmd_copyback;
  logic bus_cmd_valid, bus_cmd_write, lock_out, hold_ack;
  logic [AW-1:0] lkup_addr, cache_cmd_addr, bus_cmd_addr;
  logic [DW-1:0] resp_rdata, bus_wdata;

  locked_rmw_seq #(.AW(AW), .DW(DW)) u_locked_rmw_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .wbuf_empty(wbuf_empty), .wbuf_flush(wbuf_flush),
    .lkup_req(lkup_req), .lkup_addr(lkup_addr), .lkup_hit(lkup_hit),
    .lkup_dirty(lkup_dirty), .cache_cmd_valid(cache_cmd_valid),
    .cache_cmd_copyback(cache_cmd_copyback), .cache_cmd_addr(cache_cmd_addr),
    .cache_done(cache_done), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .lock_out(lock_out), .hold_req(hold_req), .hold_ack(hold_ack),
    .boff(boff), .ahold(ahold));

  localparam logic [1:0] K_INV = 2'd0, K_CB = 2'd1, K_RD = 2'd2, K_WR = 2'd3;

  int checks = 0, fails = 0;
  logic [AW+1:0] expq[$];
  string tag = "R4";
  logic [DW-1:0] exp_wdata = '0;
  int ccnt = 0, bcnt = 0;

  function automatic logic [DW-1:0] rd_val(logic [AW-1:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic see(logic [1:0] k, logic [AW-1:0] a);
    logic [AW+1:0] e;
    if (expq.size() == 0) chk(0, tag, "unexpected command", {k, a}, 0);
    else begin
      e = expq.pop_front();
      chk(e == {k, a}, tag, "command order", {k, a}, e);
    end
  endtask

  // responders double as scoreboard monitor
  always @(negedge clk) begin
    if (cache_done) cache_done = 0;
    else if (cache_cmd_valid) begin
      if (ccnt == 1) begin
        cache_done = 1; ccnt = 0;
        see(cache_cmd_copyback ? K_CB : K_INV, cache_cmd_addr);
        chk(!lock_out, "R6", "lock during cache command", lock_out, 0);
      end else ccnt++;
    end else ccnt = 0;
    if (bus_done) bus_done = 0;
    else if (bus_cmd_valid) begin
      if (bcnt == 1) begin
        bus_done = 1; bcnt = 0;
        bus_rdata = rd_val(bus_cmd_addr);
        see(bus_cmd_write ? K_WR : K_RD, bus_cmd_addr);
        chk(lock_out, "R7", "lock during bus command", lock_out, 1);
        if (bus_cmd_write) chk(bus_wdata == exp_wdata, "R10", "write data", bus_wdata, exp_wdata);
      end else bcnt++;
    end else bcnt = 0;
  end

  task automatic start_seq(logic [AW-1:0] a, bit hit, bit dirty, logic [DW-1:0] wd, string t);
    tag = t; lkup_hit = hit; lkup_dirty = dirty; exp_wdata = wd;
    if (hit && dirty) expq.push_back({K_CB, a});
    if (hit) expq.push_back({K_INV, a});
    expq.push_back({K_RD, a});
    expq.push_back({K_WR, a});
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(!req_ready, "R2", "ready after accept", req_ready, 0);
  endtask

  task automatic finish_seq(logic [AW-1:0] a);
    int n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    chk(resp_valid, tag, "completion pulse", resp_valid, 1);
    chk(resp_rdata == rd_val(a), "R10", "read data", resp_rdata, rd_val(a));
    chk(!lock_out, "R7", "lock after write", lock_out, 0);
    chk(expq.size() == 0, tag, "commands left", expq.size(), 0);
    @(negedge clk);
    chk(req_ready && !resp_valid, "R2", "ready after pulse", {req_ready, resp_valid}, 2'b10);
  endtask

  task automatic wait_neg(bit want_write);
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(bus_cmd_valid && bus_cmd_write == want_write) && n < 200);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !lock_out && !resp_valid && !lkup_req && !cache_cmd_valid && !bus_cmd_valid,
        "R1", "reset outputs",
        {req_ready, lock_out, resp_valid, lkup_req, cache_cmd_valid, bus_cmd_valid}, 6'b100000);

    start_seq(32'h0000_1000, 0, 0, 32'hCAFE_0001, "R4");
    finish_seq(32'h0000_1000);
    start_seq(32'h0000_2040, 1, 0, 32'hCAFE_0002, "R5");
    finish_seq(32'h0000_2040);
    start_seq(32'h0000_30C0, 1, 1, 32'hCAFE_0003, "R6");
    finish_seq(32'h0000_30C0);

    // R3: lookup waits for the write buffer
    wbuf_empty = 0;
    start_seq(32'h0000_4000, 0, 0, 32'hCAFE_0004, "R3");
    repeat (4) begin
      @(negedge clk);
      chk(!lkup_req && wbuf_flush && !bus_cmd_valid, "R3", "no lookup while draining",
          {lkup_req, wbuf_flush, bus_cmd_valid}, 3'b010);
    end
    @(posedge clk); #1; wbuf_empty = 1;
    finish_seq(32'h0000_4000);

    // R8: hold pending while the buffer empties
    wbuf_empty = 0;
    start_seq(32'h0000_5000, 1, 1, 32'hCAFE_0005, "R8");
    @(posedge clk); #1; hold_req = 1;
    @(negedge clk);
    chk(hold_ack, "R8", "grant while draining", hold_ack, 1);
    @(posedge clk); #1; wbuf_empty = 1;
    repeat (3) begin
      @(negedge clk);
      chk(hold_ack && !lkup_req && !cache_cmd_valid, "R8", "stay in drain under hold",
          {hold_ack, lkup_req, cache_cmd_valid}, 3'b100);
    end
    @(posedge clk); #1; hold_req = 0;
    wait_neg(0);
    @(posedge clk); #1; hold_req = 1;
    @(negedge clk);
    chk(!hold_ack && lock_out, "R8", "hold refused under lock", {hold_ack, lock_out}, 2'b01);
    finish_seq(32'h0000_5000);
    @(negedge clk);
    chk(hold_ack, "R8", "grant when idle", hold_ack, 1);
    @(posedge clk); #1; hold_req = 0;

    // R9: back-off on the read, address hold on the write
    start_seq(32'h0000_6080, 1, 0, 32'hCAFE_0006, "R9");
    wait_neg(0);
    @(posedge clk); #1; boff = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!bus_cmd_valid && lock_out, "R9", "read paused by boff", {bus_cmd_valid, lock_out}, 2'b01);
    end
    @(posedge clk); #1; boff = 0;
    wait_neg(1);
    @(posedge clk); #1; ahold = 1;
    repeat (2) begin
      @(negedge clk);
      chk(!bus_cmd_valid && lock_out, "R9", "write paused by ahold", {bus_cmd_valid, lock_out}, 2'b01);
    end
    @(posedge clk); #1; ahold = 0;
    finish_seq(32'h0000_6080);

    // R2: request during a sequence is ignored
    start_seq(32'h0000_7000, 0, 0, 32'hCAFE_0007, "R2");
    @(posedge clk); #1; req_valid = 1; req_addr = 32'h0000_9990; req_wdata = 32'hBAD0_BAD0;
    repeat (2) @(posedge clk); #1; req_valid = 0;
    finish_seq(32'h0000_7000);
    repeat (10) @(negedge clk);
    chk(!cache_cmd_valid && !bus_cmd_valid && req_ready, "R2", "no extra sequence",
        {cache_cmd_valid, bus_cmd_valid, req_ready}, 3'b001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule